// File: doc/BRIEF.md
# USB PHY Low-Power Sequencer

This block steps a USB 2.0 PHY into suspend and back out. It owns three pieces of PHY control state: a 32-bit power-down vector, where a one powers a section off, a clock-gate control, and the host disconnect-detect enable. A suspend request powers the PHY down and then gates its clock. A resume request ungates the clock and then powers the PHY back up. The block reports `busy_o` while a sequence runs and pulses `done_o` once when a sequence finishes.

A low-speed device is one whose full-speed D− receiver reads 1 while its D+ receiver reads 0. If such a device is attached and VBUS is valid when suspend is accepted, one receiver section (bit 22) is left powered. The PHY needs time to move onto its slow clock before that partial power-down, and again before resume. The block counts slow-clock ticks for that wait. Connect and disconnect events, each tagged with a speed, drive the disconnect-detect enable on their own and do not depend on the suspend state.

Top module: `usb_lp_seq`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `pwd_o` is 0, `clk_gate_o` is 0, `disc_det_en_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A suspend request accepted without the low-speed-with-VBUS condition drives `pwd_o` to 0xFFFFFFFF two clock edges after acceptance, with no slow-clock wait. `clk_gate_o` rises one edge later.
- R3: A low-speed line state (`dm_fs_i`=1, `dp_fs_i`=0) together with `vbus_valid_i`=1 at acceptance makes the suspend value 0xFFBFFFFF, so bit 22 stays at 0. Every other line or VBUS combination gives 0xFFFFFFFF.
- R4: On the partial path, `pwd_o` stays 0 until `SWITCH_TICKS` (default 12) slow ticks have been seen after acceptance. The partial value appears one edge after the edge that counts the last tick, and the clock is gated one edge later.
- R5: An accepted resume request waits `SWITCH_TICKS` slow ticks. On the edge after the last tick, `clk_gate_o` falls. On the following edge, `pwd_o` becomes 0.
- R6: Suspend and resume requests that arrive while `busy_o` is high have no effect. A suspend request while suspended and a resume request while powered also have no effect.
- R7: `busy_o` is high from the edge that accepts a request until the sequence ends. `done_o` is high for exactly one cycle, on the cycle in which the final action of the sequence becomes visible.
- R8: A connect event with `speed_i`=2'b10 (high speed) sets `disc_det_en_o` on the next edge. A connect with 2'b00 (low) or 2'b01 (full) leaves it unchanged.
- R9: A disconnect event clears `disc_det_en_o` on the next edge, whatever speed it reports. This includes a disconnect in the same cycle as a high-speed connect.
- R10: The line levels and VBUS are sampled only in the cycle the suspend request is accepted. Later changes do not alter the suspend value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| suspend_req_i | input | 1 | Request to enter suspend |
| resume_req_i | input | 1 | Request to leave suspend |
| dp_fs_i | input | 1 | Full-speed D+ receiver level |
| dm_fs_i | input | 1 | Full-speed D− receiver level |
| vbus_valid_i | input | 1 | VBUS valid status |
| connect_i | input | 1 | Device connect event, one cycle |
| disconnect_i | input | 1 | Device disconnect event, one cycle |
| speed_i | input | 2 | Event speed: 00 low, 01 full, 10 high |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| pwd_o | output | 32 | Power-down vector, 1 = section off |
| clk_gate_o | output | 1 | PHY clock gate, 1 = gated |
| disc_det_en_o | output | 1 | Host disconnect-detect enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle sequence-complete pulse |

## Verification
A miscounted clock-switch wait shows up on `pwd_o` or `clk_gate_o` one tick early or late. The bench checks for this by watching both outputs after every tick. A mis-latched low-speed flag shows up as the wrong suspend value on the second edge after the wait ends. An ordering fault shows `clk_gate_o` and `pwd_o` changing in the same cycle, or in the wrong order, within three edges. A stuck or lost sequence state leaves `busy_o` high or makes `done_o` repeat.

// File: rtl/usb_lp_pkg.sv
package usb_lp_pkg;

  typedef enum logic [2:0] {
    ST_ON,
    ST_SUS_WAIT,
    ST_SUS_PWD,
    ST_SUS_GATE,
    ST_OFF,
    ST_RES_WAIT,
    ST_RES_UNGATE,
    ST_RES_PWR
  } lp_state_e;

  typedef enum logic [1:0] {
    SPD_LS = 2'b00,
    SPD_FS = 2'b01,
    SPD_HS = 2'b10
  } usb_speed_e;

  function automatic logic is_low_speed(logic dp, logic dm);
    return dm & ~dp;
  endfunction

endpackage

// File: rtl/usb_lp_timer.sv
module usb_lp_timer #(
  parameter int TICKS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = en_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4

endmodule

// File: rtl/usb_lp_fsm.sv
module usb_lp_fsm
  import usb_lp_pkg::*;
#(
  parameter int PWD_W    = 32,
  parameter int KEEP_BIT = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             suspend_req_i,
  input  logic             resume_req_i,
  input  logic             ls_vbus_i,
  input  logic             wait_done_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [PWD_W-1:0] pwd_o,
  output logic             clk_gate_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [PWD_W-1:0] KEEP_MASK = ~(PWD_W'(1) << KEEP_BIT);

  lp_state_e        state_q, state_d;
  logic [PWD_W-1:0] pwd_q;
  logic             gate_q, done_q, partial_q;

  always_comb begin
    state_d   = state_q;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_ON: if (suspend_req_i) begin
        tmr_clr_o = 1'b1;
        state_d   = ls_vbus_i ? ST_SUS_WAIT : ST_SUS_PWD;
      end
      ST_SUS_WAIT:   if (wait_done_i) state_d = ST_SUS_PWD;
      ST_SUS_PWD:    state_d = ST_SUS_GATE;
      ST_SUS_GATE:   state_d = ST_OFF;
      ST_OFF: if (resume_req_i) begin
        tmr_clr_o = 1'b1;
        state_d   = ST_RES_WAIT;
      end
      ST_RES_WAIT:   if (wait_done_i) state_d = ST_RES_UNGATE;
      ST_RES_UNGATE: state_d = ST_RES_PWR;
      ST_RES_PWR:    state_d = ST_ON;
      default:       state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ON;
      pwd_q     <= '0;
      gate_q    <= 1'b0;
      done_q    <= 1'b0;
      partial_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == ST_ON && suspend_req_i) partial_q <= ls_vbus_i;
      case (state_q)
        ST_SUS_PWD:    pwd_q  <= partial_q ? KEEP_MASK : '1;
        ST_SUS_GATE: begin
          gate_q <= 1'b1;
          done_q <= 1'b1;
        end
        ST_RES_UNGATE: gate_q <= 1'b0;
        ST_RES_PWR: begin
          pwd_q  <= '0;
          done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tmr_en_o   = (state_q == ST_SUS_WAIT) || (state_q == ST_RES_WAIT);
  assign busy_o     = (state_q != ST_ON) && (state_q != ST_OFF);
  assign pwd_o      = pwd_q;
  assign clk_gate_o = gate_q;
  assign done_o     = done_q;

  AST_GATE_AFTER_PWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> ($past(pwd_q) != '0)); // R2
  AST_PWRUP_AFTER_UNGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pwd_q) != '0) && (pwd_q == '0)) |-> !$past(gate_q)); // R5
  AST_PWD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwd_q == '0) || (pwd_q == '1) || (pwd_q == KEEP_MASK)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7

endmodule

// File: rtl/usb_lp_disc.sv
module usb_lp_disc
  import usb_lp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       connect_i,
  input  logic       disconnect_i,
  input  logic [1:0] speed_i,
  output logic       en_o
);
  logic en_q;
  logic hs_conn;

  assign hs_conn = connect_i && (usb_speed_e'(speed_i) == SPD_HS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   en_q <= 1'b0;
    else if (disconnect_i && en_q) en_q <= 1'b0;
    else if (hs_conn && !disconnect_i) en_q <= 1'b1;
  end

  assign en_o = en_q;

  AST_SET_ONLY_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(hs_conn)); // R8
  AST_DISC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_i |=> !en_q); // R9

endmodule

// File: rtl/usb_lp_seq.sv
module usb_lp_seq
  import usb_lp_pkg::*;
#(
  parameter int PWD_W        = 32,
  parameter int KEEP_BIT     = 22,
  parameter int SWITCH_TICKS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             suspend_req_i,
  input  logic             resume_req_i,
  input  logic             dp_fs_i,
  input  logic             dm_fs_i,
  input  logic             vbus_valid_i,
  input  logic             connect_i,
  input  logic             disconnect_i,
  input  logic [1:0]       speed_i,
  input  logic             slow_tick_i,
  output logic [PWD_W-1:0] pwd_o,
  output logic             clk_gate_o,
  output logic             disc_det_en_o,
  output logic             busy_o,
  output logic             done_o
);
  logic ls_vbus, tmr_clr, tmr_en, tmr_exp;

  assign ls_vbus = is_low_speed(dp_fs_i, dm_fs_i) && vbus_valid_i;

  usb_lp_timer #(.TICKS(SWITCH_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .tick_i    (slow_tick_i),
    .expired_o (tmr_exp)
  );

  usb_lp_fsm #(.PWD_W(PWD_W), .KEEP_BIT(KEEP_BIT)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .suspend_req_i (suspend_req_i),
    .resume_req_i  (resume_req_i),
    .ls_vbus_i     (ls_vbus),
    .wait_done_i   (tmr_exp),
    .tmr_clr_o     (tmr_clr),
    .tmr_en_o      (tmr_en),
    .pwd_o         (pwd_o),
    .clk_gate_o    (clk_gate_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  usb_lp_disc u_disc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .connect_i    (connect_i),
    .disconnect_i (disconnect_i),
    .speed_i      (speed_i),
    .en_o         (disc_det_en_o)
  );

  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7

endmodule

// File: tb/usb_lp_seq_tb.sv
module usb_lp_seq_tb;
  localparam int TICKS = 12;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] KEEP = 32'hFFBF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sus = 0, res = 0, dp = 0, dm = 0, vb = 0, con = 0, dis = 0, tick = 0;
  logic [1:0] spd = 2'b00;
  logic [31:0] pwd;
  logic gate, den, busy, done;
  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] held_pwd;

  always #5 clk = ~clk;

  usb_lp_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .suspend_req_i(sus), .resume_req_i(res),
    .dp_fs_i(dp), .dm_fs_i(dm), .vbus_valid_i(vb), .connect_i(con),
    .disconnect_i(dis), .speed_i(spd), .slow_tick_i(tick),
    .pwd_o(pwd), .clk_gate_o(gate), .disc_det_en_o(den), .busy_o(busy), .done_o(done)
  );

  function automatic logic [31:0] exp_sus(logic p, logic m, logic v);
    return (m && !p && v) ? KEEP : ONES;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input int gap, input logic poke,
                       input logic [31:0] epwd, input logic egate, input string req);
    for (int k = 0; k < n; k++) begin
      for (int g = 1; g < gap; g++) begin
        tick = 0; sus = poke; res = poke; cyc();
        chk(req, pwd, epwd); chk(req, {31'b0, gate}, {31'b0, egate});
      end
      tick = 1; sus = poke; res = poke; cyc();
      tick = 0; sus = 0; res = 0;
      chk(req, pwd, epwd); chk(req, {31'b0, busy}, 32'd1);
    end
  endtask

  task automatic do_suspend(input logic p, input logic m, input logic v,
                            input int gap, input logic poke);
    logic [31:0] e;
    e = exp_sus(p, m, v);
    dp = p; dm = m; vb = v; sus = 1; cyc();
    sus = 0; dp = ~p; dm = ~m; vb = ~v;
    chk("R7 busy on accept", {31'b0, busy}, 32'd1);
    chk("R2 pwd not yet", pwd, 32'd0);
    if (e == KEEP) ticks(TICKS, gap, poke, 32'd0, 1'b0, "R4 wait before partial");
    cyc();
    chk(e == KEEP ? "R3 partial value" : "R2 full value", pwd, e);
    chk("R2 gate after pwd", {31'b0, gate}, 32'd0);
    cyc();
    chk("R2 gate set", {31'b0, gate}, 32'd1);
    chk("R7 done pulse", {31'b0, done}, 32'd1);
    chk("R10 value held", pwd, e);
    cyc();
    chk("R7 done one cycle", {31'b0, done}, 32'd0);
    chk("R7 busy end", {31'b0, busy}, 32'd0);
    held_pwd = pwd;
  endtask

  task automatic do_resume(input int gap, input logic poke);
    res = 1; cyc(); res = 0;
    chk("R5 busy on accept", {31'b0, busy}, 32'd1);
    ticks(TICKS, gap, poke, held_pwd, 1'b1, "R5 wait before ungate");
    chk("R5 gate held at expiry", {31'b0, gate}, 32'd1);
    cyc();
    chk("R5 ungate", {31'b0, gate}, 32'd0);
    chk("R5 pwd still off", pwd, held_pwd);
    cyc();
    chk("R5 power up", pwd, 32'd0);
    chk("R7 done resume", {31'b0, done}, 32'd1);
    cyc();
    chk("R7 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(); cyc();
    chk("R1 pwd reset", pwd, 32'd0);
    chk("R1 flags reset", {27'b0, gate, den, busy, done}, 32'd0);
    rst_n = 1; cyc();
    chk("R1 pwd after reset", pwd, 32'd0);
    chk("R1 flags after reset", {27'b0, gate, den, busy, done}, 32'd0);

    // R6: resume while powered is ignored
    res = 1; cyc(); res = 0; cyc();
    chk("R6 resume ignored", {31'b0, busy}, 32'd0);
    chk("R6 resume ignored pwd", pwd, 32'd0);

    do_suspend(1'b0, 1'b0, 1'b1, 1, 1'b0);
    // R6: suspend while suspended is ignored
    sus = 1; cyc(); sus = 0; cyc();
    chk("R6 suspend ignored", {31'b0, busy}, 32'd0);
    do_resume(1, 1'b0);

    do_suspend(1'b0, 1'b1, 1'b1, 3, 1'b1);   // R3/R4/R6 partial with requests held
    do_resume(2, 1'b1);
    do_suspend(1'b0, 1'b1, 1'b0, 1, 1'b0);   // R3 no VBUS -> full
    do_resume(1, 1'b0);

    for (int i = 0; i < 20; i++) begin
      do_suspend(1'($urandom), 1'($urandom), 1'($urandom), 1 + ($urandom % 4), 1'($urandom));
      do_resume(1 + ($urandom % 4), 1'($urandom));
    end

    // disconnect-detect control
    con = 1; spd = 2'b01; cyc(); con = 0;
    chk("R8 FS connect no set", {31'b0, den}, 32'd0);
    con = 1; spd = 2'b00; cyc(); con = 0;
    chk("R8 LS connect no set", {31'b0, den}, 32'd0);
    con = 1; spd = 2'b10; cyc(); con = 0;
    chk("R8 HS connect sets", {31'b0, den}, 32'd1);
    con = 1; spd = 2'b01; cyc(); con = 0;
    chk("R8 FS connect keeps", {31'b0, den}, 32'd1);
    dis = 1; spd = 2'b01; cyc(); dis = 0;
    chk("R9 FS disconnect clears", {31'b0, den}, 32'd0);
    dis = 1; spd = 2'b10; cyc(); dis = 0;
    chk("R9 disconnect when clear", {31'b0, den}, 32'd0);
    con = 1; spd = 2'b10; cyc(); con = 0;
    con = 1; dis = 1; cyc(); con = 0; dis = 0;
    chk("R9 disconnect wins", {31'b0, den}, 32'd0);

    cyc();
    finish_run();
  end

endmodule